// File: doc/BRIEF.md
# Fall-Through FIFO Stack

This block is the storage core between the input register and the output register of a 4-bit FIFO slice. It is a chain of fourteen word stages. Each stage has an occupied flag. A word enters at the top stage and then moves down on its own, one stage per clock. It pauses only when the stage below it is still holding a word that is not leaving in the same cycle. The bottom stage offers its word to the output register, and the output register takes it with an acknowledge. Together with the two registers around it, one slice stores sixteen words.

The input side sees a ready signal that is high only while the top stage is empty, so a full stack holds the input register full. Reset empties every stage by clearing the occupied flags. The stored data bits are left as they were. The bottom word stays on the data output whether or not it is marked valid.

Top module: `fall_through_stack`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `out_ack` held low, the stack accepts exactly 14 words. After that `in_ready` stays 0.
- R3: `in_ready` is 1 exactly when the top stage is empty. A word is taken only on a rising edge where both `in_valid` and `in_ready` are 1. Words offered while `in_ready` is 0 are never stored.
- R4: An occupied stage passes its word to the next stage on the next edge when that stage is empty or is emptying on the same edge. A full stack that is acknowledged on every cycle therefore delivers one word per cycle.
- R5: In an empty stack, `out_valid` first reads 1 after the 14th rising edge. The edge that accepts the word counts as the first.
- R6: While `out_ack` is 0, `out_valid` and `out_data` hold their values.
- R7: `out_ack` on an edge where `out_valid` is 1 removes the bottom word on that edge.
- R8: Words leave in the order they were accepted, with none lost and none duplicated, under any pattern of `in_valid` and `out_ack`.
- R9: Reset leaves the stored data unchanged. `out_data` keeps showing the bottom stage's bits after reset, while `out_valid` is 0.
- R10: `out_ack` while `out_valid` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the occupied flags |
| in_valid | input | 1 | Input register offers a word |
| in_data | input | WIDTH | Word offered at the top |
| in_ready | output | 1 | Top stage is empty and will take a word |
| out_valid | output | 1 | Bottom stage holds a word |
| out_data | output | WIDTH | Contents of the bottom stage |
| out_ack | input | 1 | Output register takes the bottom word |

## Verification
Every port result is a function of registered state only.

- **Handshake outputs:** `in_ready`, `out_valid` and `out_data` are due one edge after the handshake that changes them.
- **Fall-through latency:** for an empty stack, the bottom shows the word thirteen edges after the accepting edge. The bench checks for low one edge before that point and for high at it.
- **Sampling and model:** the bench drives inputs and samples outputs at the falling edge between two rising edges. At that point the values of the previous edge have settled and the next handshake is already decided. A queue model advances only on the handshakes seen at that sample.

// File: rtl/fall_through_stack.sv
module fall_through_stack #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_ack
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0]            occ;
  logic [DEPTH-1:0]            move;
  logic [DEPTH-1:0]            fill;
  logic [DEPTH-1:0][WIDTH-1:0] word;
  logic [DEPTH-1:0][WIDTH-1:0] src;
  logic                        load;

  assign in_ready  = ~occ[0];
  assign load      = in_valid & in_ready;
  assign out_valid = occ[LAST];
  assign out_data  = word[LAST];

  assign move[LAST] = occ[LAST] & out_ack;
  for (genvar i = 0; i < LAST; i++) begin : g_stage
    assign move[i] = occ[i] & (~occ[i+1] | move[i+1]);

    p_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (occ[i] && !occ[i+1]) |=> (occ[i+1] && word[i+1] == $past(word[i])));
  end

  assign fill = {move[LAST-1:0], load};
  assign src  = {word[LAST-1:0], in_data};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) occ <= '0;
    else        occ <= fill | (occ & ~move);

  always_ff @(posedge clk)
    for (int i = 0; i < DEPTH; i++)
      if (fill[i]) word[i] <= src[i];

  p_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (occ[0] && word[0] == $past(in_data)));

  p_no_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ[0] && !move[0]) |=> (occ[0] && $stable(word[0])));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ack) |=> (out_valid && $stable(out_data)));

  p_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ack && !occ[LAST-1]) |=> !out_valid);

  p_idle_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !occ[LAST-1]) |=> !out_valid);
endmodule

// File: tb/fall_through_stack_tb.sv
`timescale 1ns/1ps
module fall_through_stack_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_data = '0;
  logic       in_ready;
  logic       out_valid;
  logic [3:0] out_data;
  logic       out_ack = 1'b0;

  int checks = 0;
  int fails = 0;
  int accepted = 0;
  logic [3:0] q[$];

  always #4 clk = ~clk;

  fall_through_stack u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ack(out_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // At a falling edge: drive, account the handshake, advance one cycle.
  task automatic step(input logic v, input logic [3:0] d, input logic a);
    logic [3:0] e;
    in_valid = v; in_data = d; out_ack = a;
    if (a && out_valid) begin
      e = (q.size() > 0) ? q.pop_front() : 4'hx;
      chk(out_data === e, "R8 order", out_data, e);
    end
    if (v && in_ready) begin
      q.push_back(d);
      accepted++;
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    in_valid = 0; out_ack = 0; rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1; q.delete();
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_latency();
    for (int k = 0; k < 3; k++) step(0, 4'h0, 1);
    chk(out_valid === 1'b0, "R10 idle ack", out_valid, 0);
    step(1, 4'hA, 0);
    for (int k = 0; k < 12; k++) step(0, 4'h0, 0);
    chk(out_valid === 1'b0, "R5 early", out_valid, 0);
    step(0, 4'h0, 0);
    chk(out_valid === 1'b1, "R5 arrive", out_valid, 1);
    chk(out_data === 4'hA, "R5 data", out_data, 4'hA);
    chk(in_ready === 1'b1, "R3 top empty", in_ready, 1);
  endtask

  task automatic t_reset_data();
    do_reset();
    chk(out_valid === 1'b0, "R9 valid cleared", out_valid, 0);
    chk(out_data === 4'hA, "R9 data kept", out_data, 4'hA);
  endtask

  task automatic t_fill();
    logic [3:0] first;
    accepted = 0;
    for (int k = 0; k < 40; k++) step(1, 4'(k + 3), 0);
    chk(accepted == 14, "R2 capacity", accepted, 14);
    chk(in_ready === 1'b0, "R2 full", in_ready, 0);
    first = out_data;
    for (int k = 0; k < 5; k++) step(1, 4'hF, 0);
    chk(accepted == 14, "R3 refused", accepted, 14);
    chk(out_valid === 1'b1 && out_data === first, "R6 hold", out_data, first);
    chk(first === 4'h3, "R8 head", first, 4'h3);
  endtask

  task automatic t_burst();
    int got = 0;
    for (int k = 0; k < 14; k++) begin
      chk(out_valid === 1'b1, "R4 back-to-back", out_valid, 1);
      if (out_valid) got++;
      step(0, 4'h0, 1);
    end
    chk(got == 14, "R7 burst count", got, 14);
    chk(out_valid === 1'b0, "R7 emptied", out_valid, 0);
    chk(q.size() == 0, "R8 none left", q.size(), 0);
  endtask

  task automatic t_random();
    logic [15:0] lf = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | lf[5], lf[11:8], lf[3] & (lf[7] | k[8]));
    end
    for (int k = 0; k < 80; k++) step(0, 4'h0, 1);
    chk(q.size() == 0, "R8 drained", q.size(), 0);
    chk(out_valid === 1'b0, "R8 empty", out_valid, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_latency();
    t_reset_data();
    t_fill();
    t_burst();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule